// File: doc/BRIEF.md
# Serial Two-Wire Register Access Slave

This block is an I2C slave that lets an external bus master read and write a small register file held elsewhere on the chip. It watches SCL and SDA, which it resynchronises to a fast internal clock. It pulls SDA low through an open-drain enable when it acknowledges or sends a zero. It can also hold SCL low through a second enable while it waits for a register value.

A write transfer carries the device address, a pointer byte and then any number of data bytes. In the pointer byte, the top bit turns on automatic stepping of the register address and the low seven bits load the address itself. A read is normally preceded by a pointer write, followed by a repeated START and the device address with the read flag. Data bytes then flow out until the master declines one.

The register side has two parts. Writes are a single-cycle strobe that is always accepted. Reads use a request/acknowledge handshake. `reg_rd_req` acts as valid and `reg_rd_ack` as ready. Once raised, the request stays high with a fixed `reg_addr` until the cycle in which `reg_rd_ack` is high. `reg_rdata` is taken in that cycle, and the request falls on the next edge. The register side applies back-pressure simply by delaying the acknowledge. While it waits, the slave stretches SCL.

Top module: `i2c_regport_slave`

## Requirements
- R1: The slave pulls SDA low in the acknowledge slot only when the seven address bits (sent first, MSB first) equal `DEV_ADDR`. On a mismatch it leaves SDA released in that slot, and for every later byte, and it makes no register access until the next START.
- R2: The first byte after an address with R/W bit (address byte LSB) equal to 0 is acknowledged. Its bits 6..0 load the register pointer, and its bit 7 set to 1 turns on auto-increment.
- R3: Each further written byte (MSB first) is acknowledged and produces exactly one cycle of `reg_wr_en`, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer.
- R4: With auto-increment on, the pointer advances by one, wrapping from 127 to 0, after every written or fetched byte. With it off, the pointer does not change.
- R5: After an address with R/W bit equal to 1, each outgoing byte is fetched from `reg_addr` = pointer through the read handshake and is sent MSB first.
- R6: A low SDA from the master in the slot after a read byte starts the next fetch. A high SDA there makes the slave release SDA and fetch nothing further.
- R7: `scl_oe` is high for as long as a read request is pending, and it falls when the acknowledge arrives.
- R8: A STOP (SDA rising while SCL is high) returns the slave to idle with both enables low. A START (SDA falling while SCL is high) at any point, including mid-byte, restarts address reception.
- R9: `reg_rd_req` stays high with `reg_addr` unchanged until `reg_rd_ack` is seen, and it falls on the following edge.
- R10: `sda_oe` changes only while the synchronised SCL is low, except when a START or STOP releases it.
- R11: During reset, `sda_oe`, `scl_oe`, `reg_wr_en` and `reg_rd_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| reg_addr | output | DATA_W-1 | Register pointer |
| reg_wdata | output | DATA_W | Write data |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_rd_req | output | 1 | Read request (valid) |
| reg_rd_ack | input | 1 | Read acknowledge (ready), data valid this cycle |
| reg_rdata | input | DATA_W | Read data |

## Verification
The bench builds the slave with `DEV_ADDR` = 7'h5A and the default two synchroniser stages and 8-bit data. The non-matching address 7'h5B differs from it only in the final address bit, so the comparison has to cover every bit. A 7-bit pointer lets a two-byte write starting at 127 reach the wrap to 0. An SCL half period of 20 internal clocks leaves room for synchroniser latency. A read-acknowledge delay of 45 cycles exceeds that half period, which forces real clock stretching, and a zero delay exercises the fastest handshake.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_SUBADR,
    ST_WDATA,
    ST_ACK,
    ST_FETCH,
    ST_TX,
    ST_MACK
  } rp_state_e;
endpackage

// File: rtl/i2c_rp_linemon.sv
module i2c_rp_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic [DATA_W-2:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr_en,
  output logic              reg_rd_req,
  input  logic              reg_rd_ack,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int AW = DATA_W - 1;
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);

  rp_state_e st, after;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shreg, tx;
  logic [AW-1:0]     ptr;
  logic              autoinc, bump, mack_ok;

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; after <= ST_IDLE; cnt <= '0;
      shreg <= '0; tx <= '0; ptr <= '0;
      autoinc <= 1'b0; bump <= 1'b0; mack_ok <= 1'b0;
      sda_oe <= 1'b0; scl_oe <= 1'b0;
      reg_wdata <= '0; reg_wr_en <= 1'b0; reg_rd_req <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0; scl_oe <= 1'b0; reg_rd_req <= 1'b0;
      end else if (start_det) begin
        st <= ST_DEVADR; cnt <= '0; bump <= 1'b0;
        sda_oe <= 1'b0; scl_oe <= 1'b0; reg_rd_req <= 1'b0;
      end else begin
        case (st)
          ST_DEVADR, ST_SUBADR, ST_WDATA: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[DATA_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (st == ST_DEVADR) begin
                if (shreg[DATA_W-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  after  <= shreg[0] ? ST_FETCH : ST_SUBADR;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_SUBADR) begin
                ptr     <= shreg[AW-1:0];
                autoinc <= shreg[DATA_W-1];
                sda_oe  <= 1'b1;
                st      <= ST_ACK;
                after   <= ST_WDATA;
              end else begin
                reg_wdata <= shreg;
                reg_wr_en <= 1'b1;
                sda_oe    <= 1'b1;
                bump      <= 1'b1;
                st        <= ST_ACK;
                after     <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= after;
              bump   <= 1'b0;
              if (bump && autoinc) ptr <= ptr + AW'(1);
              if (after == ST_FETCH) begin
                scl_oe     <= 1'b1;
                reg_rd_req <= 1'b1;
              end
            end
          end
          ST_FETCH: begin
            if (reg_rd_ack) begin
              tx         <= reg_rdata;
              sda_oe     <= ~reg_rdata[DATA_W-1];
              scl_oe     <= 1'b0;
              reg_rd_req <= 1'b0;
              cnt        <= '0;
              st         <= ST_TX;
              if (autoinc) ptr <= ptr + AW'(1);
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_MACK;
              end else begin
                tx     <= tx << 1;
                sda_oe <= ~tx[DATA_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_ok) begin
                st         <= ST_FETCH;
                scl_oe     <= 1'b1;
                reg_rd_req <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: request held with a fixed address until acknowledged
  assert_rdreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_req && !reg_rd_ack && !stop_det && !start_det) |=> (reg_rd_req && $stable(reg_addr)));
  // R9: request falls once acknowledged
  assert_rdreq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_req && reg_rd_ack) |=> !reg_rd_req);
  // R7: SCL held while a fetch is pending
  assert_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |-> scl_oe);
  // R3: write strobe lasts a single cycle
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  // R8: STOP releases every line and request
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !scl_oe && !reg_rd_req));
  // R10: data line moves only while SCL is low
  assert_sda_lowphase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_lvl));
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'h1D,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-2:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr_en,
  output logic              reg_rd_req,
  input  logic              reg_rd_ack,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_rp_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_linemon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rp_engine #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr_en(reg_wr_en),
    .reg_rd_req(reg_rd_req), .reg_rd_ack(reg_rd_ack), .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/i2c_regport_slave_bench.sv
module i2c_regport_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;
  localparam logic [6:0] DEV = 7'h5A;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata = 8'h00;
  logic reg_wr_en, reg_rd_req, reg_rd_ack = 1'b0;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regport_slave #(.DATA_W(8), .DEV_ADDR(DEV), .SYNC_STAGES(2)) u_i2c_regport_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req), .reg_rd_ack(reg_rd_ack),
    .reg_rdata(reg_rdata)
  );

  int nchk = 0, nfail = 0;
  int rd_delay = 0, n_acks = 0, n_falls = 0, n_reqs = 0, stretch = 0;
  int exp_wa[$], exp_wd[$], exp_ra[$];
  logic [7:0] mem [128];
  int mptr = 0;
  bit minc = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference register file and per-clock comparison against expected traffic
  initial begin : monitor
    logic p_req, p_sda, p_scl;
    logic [6:0] p_addr;
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) & 255);
    p_req = 0; p_sda = 0; p_scl = 1; p_addr = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (reg_wr_en) begin
          if (exp_wa.size() == 0) chk(1'b0, "R1 unexpected write", int'(reg_addr), -1);
          else begin
            int a, d;
            a = exp_wa.pop_front(); d = exp_wd.pop_front();
            chk(reg_addr == 7'(a) && reg_wdata == 8'(d), "R3 write addr/data",
                int'({reg_addr, reg_wdata}), (a << 8) | d);
          end
          mem[reg_addr] = reg_wdata;
        end
        if (reg_rd_req && !p_req) begin
          n_reqs++;
          if (exp_ra.size() == 0) chk(1'b0, "R6 unexpected fetch", int'(reg_addr), -1);
          else begin
            int a;
            a = exp_ra.pop_front();
            chk(reg_addr == 7'(a), "R5 fetch address", int'(reg_addr), a);
          end
          chk(scl_oe, "R7 stretch with request", int'(scl_oe), 1);
        end
        if (reg_rd_req && p_req && reg_addr != p_addr)
          chk(1'b0, "R9 address moved", int'(reg_addr), int'(p_addr));
        if (!reg_rd_req && p_req) begin
          chk(n_acks == n_falls + 1, "R9 drop without ack", n_acks, n_falls + 1);
          n_falls++;
        end
        if (sda_oe != p_sda && scl_line && p_scl)
          chk(1'b0, "R10 sda moved with scl high", int'(sda_oe), int'(p_sda));
        if (scl_oe && scl_m) stretch++;
      end
      p_req = reg_rd_req; p_addr = reg_addr; p_sda = sda_oe; p_scl = scl_line;
    end
  end

  // Register-side read responder
  initial begin : responder
    forever begin
      @(negedge clk);
      if (reg_rd_req && !reg_rd_ack) begin
        repeat (rd_delay) @(negedge clk);
        reg_rdata = mem[reg_addr];
        reg_rd_ack = 1'b1;
        n_acks++;
        @(negedge clk);
        reg_rd_ack = 1'b0;
      end
    end
  end

  task automatic waitn(input int n); repeat (n) @(negedge clk); endtask
  task automatic scl_up();
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_line);
  endtask
  task automatic i2c_start();
    waitn(4); sda_m = 1'b1; waitn(HALF); scl_up(); waitn(HALF);
    sda_m = 1'b0; waitn(HALF); scl_m = 1'b0;
  endtask
  task automatic i2c_stop();
    waitn(4); sda_m = 1'b0; waitn(HALF); scl_up(); waitn(HALF);
    sda_m = 1'b1; waitn(HALF);
  endtask
  task automatic wbit(input bit b);
    waitn(4); sda_m = b; waitn(HALF); scl_up(); waitn(HALF); scl_m = 1'b0;
  endtask
  task automatic rbit(output bit b);
    waitn(4); sda_m = 1'b1; waitn(HALF); scl_up();
    waitn(HALF/2); b = sda_line; waitn(HALF/2); scl_m = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = !b;
  endtask
  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(!give_ack);
  endtask

  task automatic begin_write(input logic [7:0] sub);
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R1 address ack", int'(ack), 1);
    send_byte(sub, ack);         chk(ack, "R2 pointer ack", int'(ack), 1);
    mptr = int'(sub[6:0]); minc = sub[7];
  endtask
  task automatic wr_byte(input logic [7:0] d);
    bit ack;
    exp_wa.push_back(mptr); exp_wd.push_back(int'(d));
    send_byte(d, ack); chk(ack, "R3 data ack", int'(ack), 1);
    if (minc) mptr = (mptr + 1) % 128;
  endtask
  task automatic begin_read();
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R5 read address ack", int'(ack), 1);
  endtask
  task automatic rd_byte(input bit give_ack);
    logic [7:0] d, e;
    e = mem[mptr];
    exp_ra.push_back(mptr);
    recv_byte(d, give_ack);
    chk(d == e, "R5 read data", int'(d), int'(e));
    if (minc) mptr = (mptr + 1) % 128;
  endtask
  task automatic stop_check();
    i2c_stop(); waitn(5);
    chk(!sda_oe && !scl_oe && !reg_rd_req, "R8 idle after stop", int'({sda_oe, scl_oe}), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin : watchdog
    waitn(150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin : main
    bit ack;
    waitn(5);
    chk(!sda_oe && !scl_oe && !reg_wr_en && !reg_rd_req, "R11 reset outputs",
        int'({sda_oe, scl_oe, reg_wr_en, reg_rd_req}), 0);
    rst_n = 1'b1;
    waitn(10);

    // R3/R4: auto-increment write burst
    begin_write(8'h90); wr_byte(8'hA1); wr_byte(8'hB2); wr_byte(8'hC3); stop_check();
    // R4: fixed address write
    begin_write(8'h20); wr_byte(8'h11); wr_byte(8'h22); stop_check();
    // R4: pointer wrap 127 -> 0
    begin_write(8'hFF); wr_byte(8'h5A); wr_byte(8'h6B); stop_check();

    // R1: foreign address ignored entirely
    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack); chk(!ack, "R1 foreign address released", int'(ack), 0);
    send_byte(8'h55, ack);               chk(!ack, "R1 later byte ignored", int'(ack), 0);
    stop_check();

    // R5/R6/R7: read burst after repeated start, slow responder
    rd_delay = 45;
    begin_write(8'h90);
    begin_read(); rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b0);
    waitn(6);
    chk(!sda_oe && !reg_rd_req, "R6 released after nack", int'({sda_oe, reg_rd_req}), 0);
    stop_check();
    chk(stretch > 0, "R7 clock stretched", stretch, 1);

    // R4/R5: fixed address read, fast responder
    rd_delay = 0;
    begin_write(8'h20);
    begin_read(); rd_byte(1'b1); rd_byte(1'b0);
    stop_check();

    // R8: START in the middle of a data byte restarts reception
    begin_write(8'hB0);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    begin_write(8'hC0); wr_byte(8'h77); stop_check();

    waitn(20);
    chk(n_reqs == 5, "R6 fetch count", n_reqs, 5);
    chk(exp_wa.size() == 0 && exp_ra.size() == 0, "R3 all expected traffic seen",
        exp_wa.size() + exp_ra.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule